// File: doc/BRIEF.md
# GPIO port with atomic set, clear and toggle

This block is a general-purpose I/O port of `NPINS` pins (32 by default) behind a small word-addressed register bus. Software never writes the output latch directly. It writes a bit mask to one of three write-only ports that force pins high, force pins low or invert them. No read-modify-write sequence is needed, so two agents sharing the port cannot undo each other's changes. A direction register drives the pad output enables. A read-only register returns the synchronised pin levels.

Every pin can raise an interrupt flag. A pin in edge mode sets its flag on a rising synchronised level. A pin in level mode sets its flag whenever the synchronised level is high. The mode comes in per pin on `pin_level`. A flag is sticky. Software clears it by writing a 1 to its bit, and a completion strobe from the DMA engine clears it for any pin routed to DMA. A pin still asserting in level mode raises its flag again in the next cycle.

Each access is answered in the same cycle. Read data is combinational from the address.

Top module: `gpio_atomic_port`

## Requirements
- R1: After reset the output latch, direction, flags, interrupt enables and DMA routing are all zero, and `irq` and `dma_req` are low.
- R2: A write to word address 1 (set) drives high every pin whose mask bit is 1 and leaves the other pins unchanged.
- R3: A write to word address 2 (clear) drives low every pin whose mask bit is 1 and leaves the other pins unchanged.
- R4: A write to word address 3 (toggle) inverts every pin whose mask bit is 1.
- R5: Address 0 returns the output latch and ignores writes. Addresses 1, 2 and 3 read as zero.
- R6: The direction register at address 4 is read/write (1 = output). It drives `pin_oe` bit for bit.
- R7: Address 5 returns the pin levels (1 = high) after a two-flop synchroniser. A change on `pin_in` is first visible after the second rising clock edge.
- R8: In edge mode (`pin_level` bit 0), a rising synchronised level sets flag bit n at the next edge. The flag then stays set after the pin falls.
- R9: Writing the flag register (address 6) clears each bit written as 1. Bits written as 0 are unaffected.
- R10: In level mode (`pin_level` bit 1), a flag cleared while the pin is still high reads 0 for one cycle and 1 in the cycle after.
- R11: A `dma_done` pulse clears the flags of pins routed to DMA (address 8, bit n = pin n) and no others. `dma_req` is high while any routed flag is set.
- R12: `irq` is high exactly when some flag is set whose enable bit (address 7) is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Word address |
| bus_wdata | input | NPINS | Write data / mask |
| bus_rdata | output | NPINS | Read data, same cycle |
| pin_in | input | NPINS | Raw pad input levels |
| pin_level | input | NPINS | Per-pin detect mode, 1 = level, 0 = rising edge |
| dma_done | input | 1 | DMA completion strobe |
| pin_out | output | NPINS | Output latch |
| pin_oe | output | NPINS | Output enables (direction) |
| irq | output | 1 | Combined enabled interrupt |
| dma_req | output | 1 | Pending DMA-routed flag |

## Verification
The bench walks a chain of set, clear and toggle masks that overlap earlier ones. A design that merged the masks wrongly, or toggled unmasked bits, would drift from the computed latch value. It times the synchroniser to the exact edge, so a missing or extra flop stage shows up as the pin register changing one cycle off. It checks that a zero write to the flag register keeps the flag, that a level pin reappears exactly one cycle after being cleared, and that a DMA completion leaves unrouted flags standing. A design that cleared too broadly, or let the level source override the clear, would fail there.

// File: rtl/gpio_atomic_port.sv
module gpio_atomic_port #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [NPINS-1:0]  bus_wdata,
  output logic [NPINS-1:0]  bus_rdata,
  input  logic [NPINS-1:0]  pin_in,
  input  logic [NPINS-1:0]  pin_level,
  input  logic              dma_done,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq,
  output logic              dma_req
);
  localparam logic [ADDR_W-1:0] A_OUT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_TGL = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_PIN = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_FLG = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_IEN = ADDR_W'(7);
  localparam logic [ADDR_W-1:0] A_DMA = ADDR_W'(8);

  logic [NPINS-1:0] out_q, dir_q, ien_q, dma_en_q, flag_q;
  logic [NPINS-1:0] sync1_q, sync2_q, prev_q;
  logic [NPINS-1:0] detect, clr_mask;
  logic we;

  assign we = bus_sel & bus_wr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
    end else if (we && bus_addr == A_SET) begin
      out_q <= out_q | bus_wdata;
    end else if (we && bus_addr == A_CLR) begin
      out_q <= out_q & ~bus_wdata;
    end else if (we && bus_addr == A_TGL) begin
      out_q <= out_q ^ bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= '0;
      ien_q    <= '0;
      dma_en_q <= '0;
    end else if (we) begin
      if (bus_addr == A_DIR) dir_q    <= bus_wdata;
      if (bus_addr == A_IEN) ien_q    <= bus_wdata;
      if (bus_addr == A_DMA) dma_en_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= '0;
      sync2_q <= '0;
      prev_q  <= '0;
    end else begin
      sync1_q <= pin_in;
      sync2_q <= sync1_q;
      prev_q  <= sync2_q;
    end
  end

  assign detect   = sync2_q & (pin_level | ~prev_q);
  assign clr_mask = ((we && bus_addr == A_FLG) ? bus_wdata : '0)
                  | (dma_done ? dma_en_q : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= '0;
    else        flag_q <= (flag_q | detect) & ~clr_mask;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel && !bus_wr) begin
      case (bus_addr)
        A_OUT:   bus_rdata = out_q;
        A_DIR:   bus_rdata = dir_q;
        A_PIN:   bus_rdata = sync2_q;
        A_FLG:   bus_rdata = flag_q;
        A_IEN:   bus_rdata = ien_q;
        A_DMA:   bus_rdata = dma_en_q;
        default: bus_rdata = '0;
      endcase
    end
  end

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq     = |(flag_q & ien_q);
  assign dma_req = |(flag_q & dma_en_q);
endmodule

// File: rtl/gpio_atomic_port_chk.sv
module gpio_atomic_port_chk #(
  parameter int NPINS  = 32,
  parameter int ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [NPINS-1:0]  bus_wdata,
  input logic [NPINS-1:0]  pin_out,
  input logic              irq,
  input logic              dma_done,
  input logic [NPINS-1:0]  flag_q,
  input logic [NPINS-1:0]  dma_en_q
);
  logic we;
  assign we = bus_sel & bus_wr;

  assert_set_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && bus_addr == ADDR_W'(1)) |=> pin_out == ($past(pin_out) | $past(bus_wdata)));
  assert_clr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (we && bus_addr == ADDR_W'(2)) |=> pin_out == ($past(pin_out) & ~$past(bus_wdata)));
  assert_tgl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (we && bus_addr == ADDR_W'(3)) |=> pin_out == ($past(pin_out) ^ $past(bus_wdata)));
  assert_out_ro_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (we && bus_addr == ADDR_W'(0)) |=> $stable(pin_out));
  assert_w1c_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (we && bus_addr == ADDR_W'(6)) |=> (flag_q & $past(bus_wdata)) == '0);
  assert_dma_clr_R11: assert property (@(posedge clk) disable iff (!rst_n)
    dma_done |=> (flag_q & $past(dma_en_q)) == '0);
  assert_irq_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_q == '0) |-> !irq);
endmodule

bind gpio_atomic_port gpio_atomic_port_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .pin_out(pin_out), .irq(irq), .dma_done(dma_done),
  .flag_q(flag_q), .dma_en_q(dma_en_q)
);

// File: tb/test_gpio_atomic_port.sv
module test_gpio_atomic_port;
  localparam int PERIOD = 10;
  localparam int NV = 9;
  // {word address, write mask, expected output latch}
  localparam logic [67:0] VEC [NV] = '{
    {4'd1, 32'h0000_00FF, 32'h0000_00FF},
    {4'd1, 32'hF000_0000, 32'hF000_00FF},
    {4'd2, 32'h0000_000F, 32'hF000_00F0},
    {4'd3, 32'hFF00_00FF, 32'h0F00_000F},
    {4'd2, 32'hFFFF_FFFF, 32'h0000_0000},
    {4'd3, 32'hA5A5_A5A5, 32'hA5A5_A5A5},
    {4'd1, 32'h5A5A_5A5A, 32'hFFFF_FFFF},
    {4'd3, 32'h0001_0001, 32'hFFFE_FFFE},
    {4'd0, 32'h0000_0000, 32'hFFFE_FFFE}
  };

  logic clk = 0, rst_n = 0, bus_sel = 0, bus_wr = 0, dma_done = 0;
  logic [3:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0, pin_in = '0, pin_level = '0;
  logic [31:0] bus_rdata, pin_out, pin_oe;
  logic irq, dma_req;
  int n_run = 0, n_fail = 0;

  gpio_atomic_port i_gpio_atomic_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in), .pin_level(pin_level),
    .dma_done(dma_done), .pin_out(pin_out), .pin_oe(pin_oe), .irq(irq), .dma_req(dma_req)
  );

  always #(PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  initial begin
    #(PERIOD*100000);
    n_fail++;
    $display("FAIL watchdog actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1;
    rd(4'd0, v); chk("R1 out", v, 0);
    rd(4'd4, v); chk("R1 dir", v, 0);
    rd(4'd6, v); chk("R1 flags", v, 0);
    chk("R1 irq/dma_req", {30'd0, irq, dma_req}, 0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][67:64], VEC[i][63:32]);
      chk("R2/R3/R4/R5 pin_out", pin_out, VEC[i][31:0]);
      rd(4'd0, v); chk("R2/R3/R4/R5 readback", v, VEC[i][31:0]);
    end

    rd(4'd1, v); chk("R5 set reads zero", v, 0);
    rd(4'd2, v); chk("R5 clear reads zero", v, 0);
    rd(4'd3, v); chk("R5 toggle reads zero", v, 0);

    wr(4'd4, 32'h8000_00F1);
    rd(4'd4, v); chk("R6 dir readback", v, 32'h8000_00F1);
    chk("R6 pin_oe", pin_oe, 32'h8000_00F1);

    @(negedge clk); pin_in = 32'h1;
    rd(4'd5, v); chk("R7 before edge", v, 0);
    @(negedge clk);
    rd(4'd5, v); chk("R7 after one edge", v, 0);
    @(negedge clk);
    rd(4'd5, v); chk("R7 after two edges", v, 1);
    rd(4'd6, v); chk("R8 flag not yet", v, 0);
    @(negedge clk);
    rd(4'd6, v); chk("R8 edge flag set", v, 1);
    pin_in = 0;
    repeat (4) @(negedge clk);
    rd(4'd6, v); chk("R8 flag sticky", v, 1);
    chk("R12 irq masked", {31'd0, irq}, 0);
    wr(4'd7, 32'h1);
    chk("R12 irq enabled", {31'd0, irq}, 1);
    wr(4'd6, 32'h0);
    rd(4'd6, v); chk("R9 zero write keeps", v, 1);
    wr(4'd6, 32'h1);
    rd(4'd6, v); chk("R9 one write clears", v, 0);
    chk("R12 irq drops", {31'd0, irq}, 0);

    pin_level = 32'h10; pin_in = 32'h10;
    repeat (4) @(negedge clk);
    rd(4'd6, v); chk("R10 level flag", v, 32'h10);
    wr(4'd6, 32'h10);
    rd(4'd6, v); chk("R10 cleared cycle", v, 0);
    @(negedge clk);
    rd(4'd6, v); chk("R10 re-set next cycle", v, 32'h10);

    pin_in = 0; pin_level = 0;
    repeat (3) @(negedge clk);
    wr(4'd6, 32'hFFFF_FFFF);
    wr(4'd8, 32'h100);
    pin_in = 32'h101;
    repeat (4) @(negedge clk);
    rd(4'd6, v); chk("R11 both flags", v, 32'h101);
    chk("R11 dma_req high", {31'd0, dma_req}, 1);
    dma_done = 1;
    @(negedge clk); dma_done = 0;
    rd(4'd6, v); chk("R11 only routed cleared", v, 32'h1);
    chk("R11 dma_req low", {31'd0, dma_req}, 0);
    chk("R12 irq from pin 0", {31'd0, irq}, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule